// File: doc/BRIEF.md
# Burst Direct Data-Port Controller

This block sequences 32-bit burst transfers between a host bus and a packet buffer through a dedicated chip select. That select skips register decoding entirely. Every transfer is one full dword. Writes advance one dword per rising clock while the cycle strobe is held low. Reads advance one dword per rising clock while the chip select stays low and the cycle strobe stays high. The host can stretch either kind of burst with an active-low ready-return input.

Ready-return and the direction input are captured on the falling clock edge. The rising-edge logic then sees stable values that were sampled half a cycle earlier. A read burst spends its first cycle fetching one dword ahead, so a registered dword is presented to the host on every later beat. The buffer side gets one write strobe or one read strobe per dword moved. Buffer addressing is left to a separate pointer block.

States: `ST_IDLE`, `ST_WR_BURST`, `ST_RD_PREFETCH`, `ST_RD_BURST`. Transitions:
- `ST_IDLE` goes to `ST_WR_BURST` on the first write beat.
- `ST_IDLE` goes to `ST_RD_PREFETCH` on a read start.
- `ST_RD_PREFETCH` goes to `ST_RD_BURST` on the first read strobe.
- Any burst state returns to `ST_IDLE` when the chip select is seen high on a rising edge.

Top module: `dp_burst_port`

## Requirements
- R1: While reset is asserted and just after it is released: `buf_wr_stb`, `buf_rd_stb`, `rdata_valid` and `in_burst` are 0, and `bus_rdata` is 0.
- R2: In idle, with `dcs_n` low and `lbus_mode` low, the value of `wr_dir` taken at the falling edge picks the direction (1 = write, 0 = read). A write starts only when `cyc_n` is low and no wait is pending; that first cycle already carries a write strobe. A read starts when `cyc_n` is high.
- R3: In a write burst, each cycle with `dcs_n` low, `cyc_n` low and no wait pending asserts `buf_wr_stb` for that cycle, with `buf_wdata` equal to `bus_wdata`. A cycle with `cyc_n` high moves no dword and keeps the burst open.
- R4: The first read-burst cycle is a prefetch. `in_burst` is high and a read strobe is issued only when `cyc_n` is high and no wait is pending. The dword present on `buf_rdata` at that rising edge appears on `bus_rdata`, with `rdata_valid` high, in the next cycle.
- R5: After the prefetch, every cycle with `dcs_n` low, `cyc_n` high and no wait pending issues one read strobe. It registers the next buffer dword, with `rdata_valid` high for exactly the following cycle. A cycle with `cyc_n` low pauses the read burst.
- R6: When `rdy_ret_n` is low at a falling edge, neither strobe is asserted in the cycle that edge falls within, and the state is held.
- R7: Once a burst has started, changes of `wr_dir` have no effect until the controller is back in idle.
- R8: A rising edge that sees `dcs_n` high puts the controller in idle with `in_burst` low. No strobe is asserted in any cycle with `dcs_n` high.
- R9: While `lbus_mode` is high, no burst starts from idle.
- R10: `bus_rdata` keeps its value in every cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; rising edge moves data, falling edge samples ready-return and direction |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcs_n | input | 1 | Active-low direct data-port chip select |
| cyc_n | input | 1 | Active-low cycle strobe (low paces writes, must be high for reads) |
| wr_dir | input | 1 | Direction, 1 = write, 0 = read; sampled on the falling edge |
| rdy_ret_n | input | 1 | Active-low ready-return; low at a falling edge inserts a wait state |
| lbus_mode | input | 1 | High selects the local-bus mode, in which bursts are disabled |
| bus_wdata | input | 32 | Host write dword |
| bus_rdata | output | 32 | Registered host read dword |
| rdata_valid | output | 1 | High for the cycle after each read strobe |
| buf_wr_stb | output | 1 | One-cycle strobe per dword written to the buffer |
| buf_rd_stb | output | 1 | One-cycle strobe per dword taken from the buffer |
| buf_wdata | output | 32 | Dword presented to the buffer on a write strobe |
| buf_rdata | input | 32 | Current head dword offered by the buffer |
| in_burst | output | 1 | High whenever the controller is outside idle |

## Verification
The strobes and `buf_wdata` are combinational outputs of the current state. They depend on the inputs driven early in the cycle and on the falling-edge samples taken mid-cycle. The bench therefore compares them half a nanosecond before the rising edge of the same cycle. `in_burst` reflects the state as of the last rising edge. `rdata_valid` and `bus_rdata` are due one rising edge after the strobe that caused them, so the bench model carries them forward one cycle before it compares. Inputs change one nanosecond after each rising edge, and the bench advances its modelled buffer pointer at the same point. This keeps every input stable across both edges that sample it.

// File: rtl/dp_burst_pkg.sv
`timescale 1ns/1ps
package dp_burst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_WR_BURST    = 2'd1,
        ST_RD_PREFETCH = 2'd2,
        ST_RD_BURST    = 2'd3
    } dp_state_e;
endpackage

// File: rtl/dp_negedge_sampler.sv
`timescale 1ns/1ps
// Captures slow control inputs on the falling clock edge.
module dp_negedge_sampler #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dp_burst_fsm.sv
`timescale 1ns/1ps
module dp_burst_fsm
    import dp_burst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dcs_n,
    input  logic cyc_n,
    input  logic lbus_mode,
    input  logic wait_q,
    input  logic dir_wr_q,
    output logic wr_stb,
    output logic rd_stb,
    output logic in_burst
);
    dp_state_e st, nxt;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next state and strobes.
    always_comb begin
        nxt    = st;
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (!dcs_n && !lbus_mode) begin
                    if (dir_wr_q) begin
                        if (!cyc_n && !wait_q) begin
                            wr_stb = 1'b1;
                            nxt    = ST_WR_BURST;
                        end
                    end else if (cyc_n) begin
                        nxt = ST_RD_PREFETCH;
                    end
                end
            end
            ST_WR_BURST: begin
                if (dcs_n)                    nxt    = ST_IDLE;
                else if (!cyc_n && !wait_q)   wr_stb = 1'b1;
            end
            ST_RD_PREFETCH: begin
                if (dcs_n) nxt = ST_IDLE;
                else if (cyc_n && !wait_q) begin
                    rd_stb = 1'b1;
                    nxt    = ST_RD_BURST;
                end
            end
            ST_RD_BURST: begin
                if (dcs_n)                   nxt    = ST_IDLE;
                else if (cyc_n && !wait_q)   rd_stb = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign in_burst = (st != ST_IDLE);

    assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dcs_n |=> !in_burst);

    assert_lbus_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lbus_mode && !in_burst) |=> !in_burst);
endmodule

// File: rtl/dp_read_capture.sv
`timescale 1ns/1ps
// Registers one buffer dword per read strobe toward the host.
module dp_read_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= take;
            if (take) dout <= din;
        end
    end
endmodule

// File: rtl/dp_burst_port.sv
`timescale 1ns/1ps
module dp_burst_port #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dcs_n,
    input  logic          cyc_n,
    input  logic          wr_dir,
    input  logic          rdy_ret_n,
    input  logic          lbus_mode,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rdata_valid,
    output logic          buf_wr_stb,
    output logic          buf_rd_stb,
    output logic [DW-1:0] buf_wdata,
    input  logic [DW-1:0] buf_rdata,
    output logic          in_burst
);
    localparam int NSAMP = 2;

    logic [NSAMP-1:0] samp_q;
    logic             wait_q;
    logic             dir_wr_q;

    dp_negedge_sampler #(.W(NSAMP)) u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({~rdy_ret_n, wr_dir}),
        .q     (samp_q)
    );
    assign wait_q   = samp_q[1];
    assign dir_wr_q = samp_q[0];

    dp_burst_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dcs_n     (dcs_n),
        .cyc_n     (cyc_n),
        .lbus_mode (lbus_mode),
        .wait_q    (wait_q),
        .dir_wr_q  (dir_wr_q),
        .wr_stb    (buf_wr_stb),
        .rd_stb    (buf_rd_stb),
        .in_burst  (in_burst)
    );

    dp_read_capture #(.DW(DW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (buf_rd_stb),
        .din   (buf_rdata),
        .dout  (bus_rdata),
        .valid (rdata_valid)
    );

    assign buf_wdata = bus_wdata;

    assert_wait_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q |-> (!buf_wr_stb && !buf_rd_stb));

    assert_wr_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_stb |-> (!dcs_n && !cyc_n));

    assert_rd_delivers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_stb |=> (rdata_valid && bus_rdata == $past(buf_rdata)));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_rd_stb |=> $stable(bus_rdata));
endmodule

// File: tb/sim_dp_burst_port.sv
`timescale 1ns/1ps
module sim_dp_burst_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dcs_n = 1'b1, cyc_n = 1'b1, wr_dir = 1'b0, rdy_ret_n = 1'b1, lbus_mode = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, buf_wdata, buf_rdata;
    logic        rdata_valid, buf_wr_stb, buf_rd_stb, in_burst;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    int          mst = 0;      // 0 idle, 1 write, 2 prefetch, 3 read burst
    logic        m_valid = 1'b0;
    logic [31:0] m_rdata = '0;
    int          rptr = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] word_at(input int i);
        return 32'hA500_0000 ^ (i * 32'h9E37_79B1);
    endfunction

    assign buf_rdata = word_at(rptr);

    dp_burst_port u0 (
        .clk(clk), .rst_n(rst_n), .dcs_n(dcs_n), .cyc_n(cyc_n), .wr_dir(wr_dir),
        .rdy_ret_n(rdy_ret_n), .lbus_mode(lbus_mode), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rdata_valid(rdata_valid), .buf_wr_stb(buf_wr_stb),
        .buf_rd_stb(buf_rd_stb), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .in_burst(in_burst)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive, sample before the next rising edge, then advance the model.
    task automatic step(input logic dcs, input logic cy, input logic dir, input logic rdy,
                        input logic lb, input logic [31:0] wd, input string extra);
        logic wt, e_wr, e_rd;
        int   nx;
        string t;
        dcs_n = dcs; cyc_n = cy; wr_dir = dir; rdy_ret_n = rdy; lbus_mode = lb; bus_wdata = wd;
        @(negedge clk); #1.5;
        wt = !rdy; e_wr = 1'b0; e_rd = 1'b0; nx = mst;
        case (mst)
            0: if (!dcs && !lb) begin
                   if (dir) begin
                       if (!cy && !wt) begin e_wr = 1'b1; nx = 1; end
                   end else if (cy) nx = 2;
               end
            1: if (dcs) nx = 0; else e_wr = !cy && !wt;
            2: if (dcs) nx = 0; else if (cy && !wt) begin e_rd = 1'b1; nx = 3; end
            3: if (dcs) nx = 0; else e_rd = cy && !wt;
            default: nx = 0;
        endcase
        if (extra != "")             t = extra;
        else if (dcs)                t = "R8";
        else if (lb && mst == 0)     t = "R9";
        else if (wt)                 t = "R6";
        else if (mst == 0)           t = "R2";
        else if (mst == 1)           t = "R3";
        else if (mst == 2)           t = "R4";
        else                         t = "R5";
        chk(buf_wr_stb === e_wr, {t, " wr_stb"}, {31'd0, buf_wr_stb}, {31'd0, e_wr});
        chk(buf_rd_stb === e_rd, {t, " rd_stb"}, {31'd0, buf_rd_stb}, {31'd0, e_rd});
        if (e_wr) chk(buf_wdata === wd, "R3 wdata", buf_wdata, wd);
        chk(in_burst === (mst != 0), {t, " in_burst"}, {31'd0, in_burst}, {31'd0, mst != 0});
        chk(rdata_valid === m_valid, "R5 rdata_valid", {31'd0, rdata_valid}, {31'd0, m_valid});
        chk(bus_rdata === m_rdata, "R10 bus_rdata", bus_rdata, m_rdata);
        @(posedge clk); #1;
        if (e_rd) begin m_rdata = word_at(rptr); rptr++; end
        m_valid = e_rd;
        mst = nx;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk(buf_wr_stb === 1'b0 && buf_rd_stb === 1'b0, "R1 strobes in reset", {30'd0, buf_wr_stb, buf_rd_stb}, 32'd0);
        chk(in_burst === 1'b0 && rdata_valid === 1'b0, "R1 state in reset", {30'd0, in_burst, rdata_valid}, 32'd0);
        chk(bus_rdata === 32'd0, "R1 rdata in reset", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(in_burst === 1'b0, "R1 idle after reset", {31'd0, in_burst}, 32'd0);

        // Directed write burst with pause, wait and direction flip (R3, R6, R7).
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h1000 + i, "");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h2000, "R3 pause");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h2001, "R6 write wait");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h2002, "R7 dir flip write");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h2003, "R8 write end");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "R8 idle");

        // Directed read burst with wait in prefetch, cyc pause, direction flip (R4, R5, R6, R7).
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "R2 read start");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R6 prefetch wait");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "R4 prefetch");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, "R5 cyc pause");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, "R7 dir flip read");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "R8 read end");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "R10 hold");

        // Local-bus mode blocks entry (R9).
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h3000 + i, "R9 blocked");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, "");

        // Constrained random traffic.
        begin
            logic dir_r = 1'b1;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom % 10 == 0) dir_r = ~dir_r;
                step(($urandom % 9) == 0, ($urandom % 2) == 0, dir_r, ($urandom % 5) != 0,
                     ($urandom % 16) == 0, $urandom, "");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule